// File: doc/BRIEF.md
# Handshaked Read Link Between Two Clock Domains

This block models one memory read carried over a shared bus that has no common clock. A requester, clocked by `clk_a`, and a responder, clocked by `clk_b`, exchange three control lines: a read request, an acknowledge and a data-ready strobe. They also share one data/address bus. Each side passes every control line it receives through a two-flop synchronizer before it acts on that line.

A read is made of two full four-phase handshakes in a row. In the first, the requester places the address on the bus and raises the request. The responder takes the address and acknowledges it. Both sides then return their lines to low. In the second, the responder waits a programmable latency, places the addressed word on the bus and raises data-ready. The requester takes the word and acknowledges it, and both sides again return their lines to low. The acknowledge line is a wired-OR that both sides use, the responder in the first handshake and the requester in the second.

The responder's memory is a fixed table computed from the address. A requester phase that stalls for too long ends the read with an error flag and no data.

Top module: `hs_read_link`

## Requirements
- R1: After reset, `done`, `err` and `busy` are low, `rdata` is zero, and no control line is asserted.
- R2: A `start` pulse, taken while `busy` is low, raises the read request with `addr` on the bus, and `busy` is high on the next `clk_a` cycle.
- R3: The responder raises acknowledge only after it has seen the read request high through its synchronizer, and it captures the address from the bus in that same cycle.
- R4: The requester lowers the request and stops driving the bus only after it has seen acknowledge high, unless the read timed out.
- R5: The two sides never drive the bus in the same cycle.
- R6: Data-ready rises only while the responder's own acknowledge is low and its synchronized view of the request is low. It rises at least `lat`+1 responder cycles after that acknowledge fell, so a read with `lat`=15 completes measurably later than the same read with `lat`=0.
- R7: The word returned for address a is (a*37 + 11) mod 2^DW. With the defaults (DW=8, AW=4), every address 0..15 returns its own word for every `lat` 0..15.
- R8: `done` is a one-cycle pulse in the `clk_a` cycle after the requester lowers its final acknowledge. `rdata` holds the read word while `done` is high. Each completed read produces exactly one pulse.
- R9: If any requester phase waits more than TMO (256) `clk_a` cycles, the requester sets `err`, releases all its lines, returns to idle and gives no `done`. The next `start` clears `err`.
- R10: A `start` pulse while `busy` is high is ignored. The read in progress returns the word for its original address, and no extra read follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Requester clock |
| rst_a_n | input | 1 | Requester asynchronous reset, active low |
| start | input | 1 | Begin a read (clk_a domain) |
| addr | input | AW | Address of the read |
| rdata | output | DW | Word returned by the last read |
| done | output | 1 | One-cycle pulse when a read completes |
| err | output | 1 | Sticky timeout flag, cleared by the next start |
| busy | output | 1 | Read in progress or bus acknowledge not yet settled |
| clk_b | input | 1 | Responder clock |
| rst_b_n | input | 1 | Responder asynchronous reset, active low |
| lat | input | LW | Responder latency in clk_b cycles, held stable during a read |

## Verification
The assertions check four things on every cycle. The bus has a single driver. Each control edge is caused by the synchronized edge it answers. Data-ready keeps its minimum gap from the responder's acknowledge, and `done` is a clean pulse. Some behaviour can only be shown by the bench's scenarios: that every address/latency pair returns the right word across the two unrelated clocks, that a latency of 15 costs real time, that a start given while busy changes nothing, and that a responder held in reset leads to the timeout and then to a clean recovery.

// File: rtl/hs_read_link.sv
module hs_read_link #(
  parameter int AW   = 4,
  parameter int DW   = 8,
  parameter int LW   = 4,
  parameter int TMO  = 256,
  parameter int MULT = 37,
  parameter int OFFS = 11
) (
  input  logic          clk_a,
  input  logic          rst_a_n,
  input  logic          start,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          err,
  output logic          busy,
  input  logic          clk_b,
  input  logic          rst_b_n,
  input  logic [LW-1:0] lat
);
  localparam int TW = $clog2(TMO + 1);

  typedef enum logic [2:0] {Q_IDLE, Q_ADDR, Q_REL, Q_DATA, Q_FIN} qst_t;
  typedef enum logic [2:0] {P_IDLE, P_ACK, P_LOW, P_WAIT, P_RDY, P_END} pst_t;

  qst_t          qs;
  pst_t          ps;
  logic          rq, ack_a, oe_a;
  logic          ack_b, rdy, oe_b;
  logic [AW-1:0] addr_q, ad_q;
  logic [DW-1:0] dout, word, bus;
  logic [TW-1:0] tmr;
  logic [LW-1:0] cnt;
  logic [1:0]    as1, as2, bs1, bs2;
  logic          ack_ln, ack_sa, rdy_sa, rq_sb, ack_sb;

  assign ack_ln = ack_a | ack_b;
  assign bus    = oe_a ? DW'(addr_q) : (oe_b ? dout : '0);
  assign word   = DW'(ad_q) * DW'(MULT) + DW'(OFFS);
  assign ack_sa = as2[1];
  assign rdy_sa = as2[0];
  assign rq_sb  = bs2[1];
  assign ack_sb = bs2[0];
  assign busy   = (qs != Q_IDLE) | ack_sa;

  always_ff @(posedge clk_a or negedge rst_a_n) begin
    if (!rst_a_n) begin
      qs <= Q_IDLE; rq <= 1'b0; ack_a <= 1'b0; oe_a <= 1'b0;
      addr_q <= '0; rdata <= '0; done <= 1'b0; err <= 1'b0;
      tmr <= '0; as1 <= '0; as2 <= '0;
    end else begin
      as1  <= {ack_ln, rdy};
      as2  <= as1;
      done <= 1'b0;
      tmr  <= (qs == Q_IDLE) ? '0 : tmr + 1'b1;
      if (qs != Q_IDLE && tmr == TW'(TMO)) begin
        err <= 1'b1; rq <= 1'b0; oe_a <= 1'b0; ack_a <= 1'b0;
        qs  <= Q_IDLE;
      end else begin
        case (qs)
          Q_IDLE: if (start && !ack_sa) begin
            addr_q <= addr; rq <= 1'b1; oe_a <= 1'b1; err <= 1'b0;
            tmr <= '0; qs <= Q_ADDR;
          end
          Q_ADDR: if (ack_sa) begin
            rq <= 1'b0; oe_a <= 1'b0; tmr <= '0; qs <= Q_REL;
          end
          Q_REL: if (!ack_sa) begin
            tmr <= '0; qs <= Q_DATA;
          end
          Q_DATA: if (rdy_sa) begin
            rdata <= bus; ack_a <= 1'b1; tmr <= '0; qs <= Q_FIN;
          end
          Q_FIN: if (!rdy_sa) begin
            ack_a <= 1'b0; done <= 1'b1; qs <= Q_IDLE;
          end
          default: qs <= Q_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_b or negedge rst_b_n) begin
    if (!rst_b_n) begin
      ps <= P_IDLE; ack_b <= 1'b0; rdy <= 1'b0; oe_b <= 1'b0;
      ad_q <= '0; dout <= '0; cnt <= '0; bs1 <= '0; bs2 <= '0;
    end else begin
      bs1 <= {rq, ack_ln};
      bs2 <= bs1;
      case (ps)
        P_IDLE: if (rq_sb && !ack_sb) begin
          ad_q <= bus[AW-1:0]; ack_b <= 1'b1; ps <= P_ACK;
        end
        P_ACK: if (!rq_sb) begin
          ack_b <= 1'b0; ps <= P_LOW;
        end
        P_LOW: if (!ack_sb) begin
          cnt <= lat; ps <= P_WAIT;
        end
        P_WAIT: if (cnt == '0) begin
          dout <= word; oe_b <= 1'b1; rdy <= 1'b1; ps <= P_RDY;
        end else cnt <= cnt - 1'b1;
        P_RDY: if (ack_sb) begin
          oe_b <= 1'b0; rdy <= 1'b0; ps <= P_END;
        end
        P_END: if (!ack_sb) ps <= P_IDLE;
        default: ps <= P_IDLE;
      endcase
    end
  end
endmodule

module hs_read_link_chk #(
  parameter int LW = 4
) (
  input logic          clk_a,
  input logic          rst_a_n,
  input logic          clk_b,
  input logic          rst_b_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          rq,
  input logic          ack_b,
  input logic          rdy,
  input logic          oe_a,
  input logic          oe_b,
  input logic          ack_sa,
  input logic          rq_sb,
  input logic [LW-1:0] lat
);
  logic [LW:0] gap;

  always_ff @(posedge clk_b or negedge rst_b_n) begin
    if (!rst_b_n) gap <= '0;
    else if (ack_b) gap <= '0;
    else if (gap != '1) gap <= gap + 1'b1;
  end

  AST_ONE_DRIVER: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !(oe_a && oe_b)); // R5
  AST_REQ_FROM_START: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    $rose(rq) |-> ($past(start) && !$past(busy))); // R2
  AST_REQ_DROP_ON_ACK: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    $fell(rq) |-> ($past(ack_sa) || err)); // R4
  AST_ACK_AFTER_REQ: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    $rose(ack_b) |-> $past(rq_sb)); // R3
  AST_RDY_ORDER: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    $rose(rdy) |-> (!ack_b && !$past(rq_sb))); // R6
  AST_RDY_DELAY: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    $rose(rdy) |-> ({1'b0, lat} < $past(gap))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    done |=> !done); // R8
  AST_DONE_NO_ERR: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    done |-> !err); // R9
endmodule

bind hs_read_link hs_read_link_chk #(.LW(LW)) u_chk (
  .clk_a(clk_a), .rst_a_n(rst_a_n), .clk_b(clk_b), .rst_b_n(rst_b_n),
  .start(start), .busy(busy), .done(done), .err(err),
  .rq(rq), .ack_b(ack_b), .rdy(rdy), .oe_a(oe_a), .oe_b(oe_b),
  .ack_sa(ack_sa), .rq_sb(rq_sb), .lat(lat)
);

// File: tb/hs_read_link_test.sv
module hs_read_link_test;
  localparam int AW = 4, DW = 8, LW = 4;

  logic          clk_a = 1'b0, clk_b = 1'b0;
  logic          rst_a_n = 1'b0, rst_b_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LW-1:0] lat = '0;
  logic [DW-1:0] rdata;
  logic          done, err, busy;
  int            n_chk = 0, n_bad = 0;

  always #10 clk_a = ~clk_a;
  always #17 clk_b = ~clk_b;

  hs_read_link #(.AW(AW), .DW(DW), .LW(LW)) uut (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .start(start), .addr(addr),
    .rdata(rdata), .done(done), .err(err), .busy(busy),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .lat(lat)
  );

  function automatic logic [DW-1:0] expw(input int a);
    return DW'(a * 37 + 11);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fire(input int a);
    @(negedge clk_a);
    while (busy) @(negedge clk_a);
    addr = AW'(a); start = 1'b1;
    @(negedge clk_a);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok, output realtime t);
    ok = 1'b0; t = 0;
    for (int i = 0; i < 2000; i++) begin
      if (done) begin ok = 1'b1; t = $realtime; break; end
      @(negedge clk_a);
    end
  endtask

  task automatic one_read(input int a, input string req, output realtime dt);
    bit ok; realtime t0, t1;
    fire(a);
    t0 = $realtime;
    check("R2 busy after start", busy, 1);
    wait_done(ok, t1);
    check({req, " done seen"}, ok, 1);
    check({req, " rdata"}, rdata, expw(a));
    check("R9 no err on good read", err, 0);
    @(negedge clk_a);
    check("R8 done one cycle", done, 0);
    dt = t1 - t0;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    realtime d0, d15, dt;
    bit ok; realtime tt;
    int extra;
    repeat (5) @(negedge clk_a);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 busy", busy, 0);
    check("R1 rdata", rdata, 0);
    rst_a_n = 1'b1; rst_b_n = 1'b1;
    repeat (4) @(negedge clk_a);
    check("R1 idle after release", busy, 0);

    for (int l = 0; l < 16; l++) begin
      lat = LW'(l);
      for (int a = 0; a < 16; a++) one_read(a, "R7 R3", dt);
    end

    lat = 0;  one_read(5, "R6 lat0", d0);
    lat = 15; one_read(5, "R6 lat15", d15);
    check("R6 lat15 slower by >=12 clk_b", (d15 - d0) >= 408.0, 1);

    lat = 3;
    fire(9);
    repeat (3) @(negedge clk_a);
    addr = 4'd2; start = 1'b1;
    @(negedge clk_a);
    start = 1'b0;
    wait_done(ok, tt);
    check("R10 first read done", ok, 1);
    check("R10 original word kept", rdata, expw(9));
    extra = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_a);
      if (done) extra++;
    end
    check("R10 no extra read", extra, 0);
    check("R10 idle after", busy, 0);

    rst_b_n = 1'b0;
    fire(7);
    begin
      int w;
      w = 0;
      while (!err && w < 700) begin @(negedge clk_a); if (done) extra++; w++; end
      check("R9 err raised", err, 1);
      check("R9 waited over TMO", w >= 250, 1);
      check("R9 no done on timeout", extra, 0);
    end
    @(negedge clk_a);
    check("R9 idle after timeout", busy, 0);
    rst_b_n = 1'b1;
    repeat (6) @(negedge clk_a);
    lat = 1;
    one_read(12, "R9 recovery", dt);
    check("R9 err cleared by start", err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule